// File: doc/BRIEF.md
# Instruction Fetch and Issue Stage with Per-Instruction Bubbles and Variable Delay Slots

This block is the front end of a five-stage in-order pipeline. It reads 32-bit instructions from a synchronous-SRAM instruction port, where data returns one cycle after the address, and hands one instruction or one NOP per cycle to decode through a registered issue interface. Each instruction carries a flag that asks for one hardware NOP ahead of it, so padding for data hazards never has to sit in memory.

Jumps and branches carry a small delay-slot count. After a branch is issued, the stage issues that many following sequential instructions. It then issues NOPs until execute reports the outcome. A taken outcome throws away every wrong-path word still in flight and restarts fetch at the target. A not-taken outcome lets the sequential stream carry on with nothing dropped. A stall from later stages freezes the stage and keeps all pending state.

Top module: `fetch_issue`

## Requirements
- R1: While reset is high, the issue output is a NOP (issue_valid 0, issue_instr equal to NOP_WORD). The first address presented after reset is RESET_VEC, and the first real instruction issued comes from RESET_VEC.
- R2: With no flags, branches or stalls, one real instruction is issued per cycle. Back-to-back real issues have PCs that differ by exactly 4.
- R3: An instruction with bit 31 set is issued exactly one cycle later than it would be otherwise, with one NOP cycle directly in front of it.
- R4: An instruction whose bits 30:28 equal BR_OPCODE (default 3'b111) is a branch, and bits 27:26 are its slot count S (0 to 3). After the branch, at most S real instructions are issued before its outcome arrives. Until then the stage issues NOPs.
- R5: On a taken outcome, the S sequential instructions after the branch are issued, and the next real instruction comes from the target. No later sequential word is issued.
- R6: On a not-taken outcome, issue resumes at the next sequential instruction, and no instruction is skipped.
- R7: A bubble requested by bit 31 inside a delay-slot window does not count as one of the S slot instructions.
- R8: While stall is high, issue_instr, issue_pc, issue_valid and imem_addr hold their values. The pending bubble and the slot count survive the stall.
- R9: With S = 0, the first real instruction after a taken branch comes from the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze request from later stages |
| br_resolve | input | 1 | Execute reports the outcome of the open branch this cycle |
| br_taken | input | 1 | Outcome of the reported branch: 1 = taken |
| br_target | input | ADDR_W | Target address of the reported branch |
| imem_addr | output | ADDR_W | Read address to the instruction SRAM |
| imem_rdata | input | 32 | Read data, valid one cycle after the address |
| issue_valid | output | 1 | 1 = real instruction on issue_instr, 0 = NOP |
| issue_instr | output | 32 | Instruction word handed to decode |
| issue_pc | output | ADDR_W | Address of the issued instruction |

## Verification
The properties assume that br_resolve rises only while a branch window is open, once per branch and never during a stall. They also assume that no branch sits inside another branch's delay slots and that the SRAM always answers the address from the previous cycle. The stimulus respects these limits. Each outcome is raised by a task that first watches the issue port for the branch and then waits a fixed number of cycles. Branches sit among plain sequential filler words. The stall is only raised while no outcome is due.

// File: rtl/fetch_issue_pkg.sv
package fetch_issue_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned SLOT_W    = 2;
  localparam int unsigned OP_W      = 3;
  localparam int unsigned NFLAG_POS = 31;
  localparam int unsigned OP_LSB    = 28;
  localparam int unsigned SLOT_LSB  = 26;

  typedef logic [INSTR_W-1:0] word_t;
  typedef logic [SLOT_W-1:0]  slot_t;
  typedef logic [OP_W-1:0]    opc_t;

  function automatic logic wants_bubble(word_t w);
    return w[NFLAG_POS];
  endfunction

  function automatic logic is_branch(word_t w, opc_t opc);
    return w[OP_LSB +: OP_W] == opc;
  endfunction

  function automatic slot_t slot_count(word_t w);
    return w[SLOT_LSB +: SLOT_W];
  endfunction
endpackage

// File: rtl/fi_slot_track.sv
module fi_slot_track
  import fetch_issue_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              consume,
  input  logic              consume_br,
  input  slot_t             consume_slot,
  input  logic              br_resolve,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic              hold,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_tgt
);
  logic              win_open;
  logic              pend_taken;
  slot_t             left;
  logic [ADDR_W-1:0] pend_tgt;
  logic              drained;

  assign drained   = win_open && (left == '0);
  assign hold      = drained && !pend_taken && !br_resolve;
  assign flush     = !stall && drained && (pend_taken || (br_resolve && br_taken));
  assign flush_tgt = pend_taken ? pend_tgt : br_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_open   <= 1'b0;
      pend_taken <= 1'b0;
      left       <= '0;
      pend_tgt   <= '0;
    end else if (!stall) begin
      if (flush) begin
        win_open   <= 1'b0;
        pend_taken <= 1'b0;
        left       <= '0;
      end else if (consume && consume_br) begin
        win_open   <= 1'b1;
        pend_taken <= 1'b0;
        left       <= consume_slot;
      end else if (win_open && br_resolve && !br_taken) begin
        win_open <= 1'b0;
        left     <= '0;
      end else begin
        if (win_open && br_resolve && br_taken) begin
          pend_taken <= 1'b1;
          pend_tgt   <= br_target;
        end
        if (consume && win_open && (left != '0)) left <= left - slot_t'(1);
      end
    end
  end
endmodule

// File: rtl/fi_pc_gen.sv
module fi_pc_gen
  import fetch_issue_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              consume,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_tgt,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_pc,
  output logic [ADDR_W-1:0] imem_addr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_W / 8);

  always_comb begin
    if (stall)        imem_addr = rd_pc;
    else if (flush)   imem_addr = flush_tgt;
    else if (consume) imem_addr = rd_pc + STEP;
    else              imem_addr = rd_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_pc    <= RESET_VEC;
    end else if (!stall) begin
      rd_valid <= 1'b1;
      rd_pc    <= imem_addr;
    end
  end
endmodule

// File: rtl/fi_issue_reg.sv
module fi_issue_reg
  import fetch_issue_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter word_t             NOP_WORD  = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              consume,
  input  logic              flush,
  input  logic              hold,
  input  logic              rd_valid,
  input  word_t             word,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              bubble_req,
  output logic              issue_valid,
  output word_t             issue_instr,
  output logic [ADDR_W-1:0] issue_pc
);
  logic bubble_done;

  assign bubble_req = rd_valid && wants_bubble(word) && !bubble_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      bubble_done <= 1'b0;
    end else if (!stall) begin
      if (flush || consume)        bubble_done <= 1'b0;
      else if (bubble_req && !hold) bubble_done <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_instr <= NOP_WORD;
      issue_pc    <= RESET_VEC;
    end else if (!stall) begin
      if (consume) begin
        issue_valid <= 1'b1;
        issue_instr <= word;
        issue_pc    <= rd_pc;
      end else begin
        issue_valid <= 1'b0;
        issue_instr <= NOP_WORD;
      end
    end
  end
endmodule

// File: rtl/fetch_issue.sv
module fetch_issue
  import fetch_issue_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0,
  parameter logic [31:0]       NOP_WORD  = '0,
  parameter logic [2:0]        BR_OPCODE = 3'b111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              br_resolve,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  output logic [ADDR_W-1:0] imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              issue_valid,
  output logic [31:0]       issue_instr,
  output logic [ADDR_W-1:0] issue_pc
);
  logic              hold;
  logic              flush;
  logic [ADDR_W-1:0] flush_tgt;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_pc;
  logic              bubble_req;
  logic              consume;

  assign consume = !stall && rd_valid && !flush && !hold && !bubble_req;

  fi_slot_track #(.ADDR_W(ADDR_W)) u_slots (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .consume      (consume),
    .consume_br   (is_branch(imem_rdata, BR_OPCODE)),
    .consume_slot (slot_count(imem_rdata)),
    .br_resolve   (br_resolve),
    .br_taken     (br_taken),
    .br_target    (br_target),
    .hold         (hold),
    .flush        (flush),
    .flush_tgt    (flush_tgt)
  );

  fi_pc_gen #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .consume   (consume),
    .flush     (flush),
    .flush_tgt (flush_tgt),
    .rd_valid  (rd_valid),
    .rd_pc     (rd_pc),
    .imem_addr (imem_addr)
  );

  fi_issue_reg #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC), .NOP_WORD(NOP_WORD)) u_issue (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .consume     (consume),
    .flush       (flush),
    .hold        (hold),
    .rd_valid    (rd_valid),
    .word        (imem_rdata),
    .rd_pc       (rd_pc),
    .bubble_req  (bubble_req),
    .issue_valid (issue_valid),
    .issue_instr (issue_instr),
    .issue_pc    (issue_pc)
  );
endmodule

// File: rtl/fetch_issue_chk.sv
module fetch_issue_chk #(
  parameter int unsigned       ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [ADDR_W-1:0] imem_addr,
  input logic              issue_valid,
  input logic [31:0]       issue_instr,
  input logic [ADDR_W-1:0] issue_pc
);
  logic primed;
  always_ff @(posedge clk) primed <= 1'b1;

  AST_RESET_NOP: assert property (@(posedge clk) disable iff (!primed)
    rst |=> !issue_valid);  // R1

  AST_RESET_FETCH: assert property (@(posedge clk) disable iff (!primed || rst)
    $past(rst) |-> imem_addr == RESET_VEC);  // R1

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!primed || rst)
    (issue_valid && $past(issue_valid) && !$past(stall) && !$past(rst))
      |-> issue_pc == $past(issue_pc) + ADDR_W'(4));  // R2

  AST_BUBBLE_FIRST: assert property (@(posedge clk) disable iff (!primed || rst)
    (issue_valid && issue_instr[31] && !$past(stall)) |-> !$past(issue_valid));  // R3

  AST_STALL_ISSUE: assert property (@(posedge clk) disable iff (!primed || rst)
    stall |=> ($stable(issue_valid) && $stable(issue_instr) && $stable(issue_pc)));  // R8

  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!primed || rst)
    (stall && $past(stall) && !$past(rst)) |-> $stable(imem_addr));  // R8
endmodule

bind fetch_issue fetch_issue_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stall       (stall),
  .imem_addr   (imem_addr),
  .issue_valid (issue_valid),
  .issue_instr (issue_instr),
  .issue_pc    (issue_pc)
);

// File: tb/fetch_issue_bench.sv
module fetch_issue_bench;
  localparam logic [31:0] RV   = 32'h0000_0040;
  localparam logic [31:0] NOPW = 32'h0000_0000;
  localparam logic [31:0] BPC  = RV + 32'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic        br_resolve = 1'b0;
  logic        br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic        issue_valid;
  logic [31:0] issue_instr;
  logic [31:0] issue_pc;

  always #5 clk = ~clk;

  fetch_issue #(.RESET_VEC(RV), .NOP_WORD(NOPW)) u_fetch_issue (
    .clk(clk), .rst(rst), .stall(stall), .br_resolve(br_resolve),
    .br_taken(br_taken), .br_target(br_target), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .issue_valid(issue_valid),
    .issue_instr(issue_instr), .issue_pc(issue_pc)
  );

  logic [31:0] mem [0:255];
  always @(posedge clk) imem_rdata <= mem[imem_addr[9:2]];

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic stall_at_edge = 1'b0;
  int n = 0;
  logic [31:0] lpc [0:63];
  int lcyc [0:63];

  always @(posedge clk) begin
    cyc = cyc + 1;
    stall_at_edge = stall;
  end

  always @(negedge clk)
    if (!rst && issue_valid && !stall_at_edge && n < 64) begin
      lpc[n] = issue_pc;
      lcyc[n] = cyc;
      n = n + 1;
    end

  always @(posedge clk)
    if (cyc > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0A00_0000 | 32'(i);
  endtask

  function automatic logic [31:0] br_word(input int slot, input int idx);
    return {1'b0, 3'b111, 2'(slot), 26'(idx)};
  endfunction

  function automatic int find_pc(input logic [31:0] pc);
    for (int i = 0; i < n; i++) if (lpc[i] == pc) return i;
    return -1;
  endfunction

  function automatic logic [31:0] log_at(input int b, input int off);
    if (b < 0 || b + off >= n) return 32'hDEAD_DEAD;
    return lpc[b + off];
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    stall = 1'b0;
    br_resolve = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic wait_branch();
    do begin
      @(negedge clk);
      #1;
    end while (!(issue_valid && issue_instr[30:28] == 3'b111));
  endtask

  task automatic resolve_after(input int d, input bit taken, input logic [31:0] tgt);
    wait_branch();
    repeat (d) @(negedge clk);
    br_resolve = 1'b1;
    br_taken = taken;
    br_target = tgt;
    @(negedge clk);
    br_resolve = 1'b0;
  endtask

  task automatic t_reset_and_stream();
    bit seq_ok;
    load_mem();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(issue_valid == 1'b0, "R1", "valid in reset", 32'(issue_valid), 32'd0);
    check(issue_instr == NOPW, "R1", "instr in reset", issue_instr, NOPW);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    #1;
    check(imem_addr == RV, "R1", "first fetch address", imem_addr, RV);
    repeat (10) @(negedge clk);
    #1;
    check(n == 9, "R2", "issue count over 10 cycles", 32'(n), 32'd9);
    check(lpc[0] == RV, "R1", "first issued pc", lpc[0], RV);
    seq_ok = 1'b1;
    for (int i = 0; i < 8; i++) if (lpc[i+1] != lpc[i] + 32'd4) seq_ok = 1'b0;
    check(seq_ok, "R2", "pc steps of 4", lpc[8], RV + 32'd32);
    check(lcyc[8] - lcyc[0] == 8, "R2", "one issue per cycle", 32'(lcyc[8] - lcyc[0]), 32'd8);
  endtask

  task automatic t_nflag();
    load_mem();
    mem[(RV >> 2) + 3] = mem[(RV >> 2) + 3] | 32'h8000_0000;
    do_reset();
    repeat (12) @(negedge clk);
    #1;
    check(lpc[3] == RV + 32'd12, "R3", "flagged word still issued", lpc[3], RV + 32'd12);
    check(lcyc[3] - lcyc[2] == 2, "R3", "one bubble before flagged", 32'(lcyc[3] - lcyc[2]), 32'd2);
    check(lcyc[4] - lcyc[3] == 1, "R3", "no bubble after flagged", 32'(lcyc[4] - lcyc[3]), 32'd1);
  endtask

  task automatic t_taken_slots();
    int b;
    load_mem();
    mem[BPC >> 2] = br_word(2, 0);
    do_reset();
    resolve_after(1, 1'b1, 32'h200);
    repeat (6) @(negedge clk);
    #1;
    b = find_pc(BPC);
    check(log_at(b, 1) == BPC + 32'd4, "R5", "first slot", log_at(b, 1), BPC + 32'd4);
    check(log_at(b, 2) == BPC + 32'd8, "R5", "second slot", log_at(b, 2), BPC + 32'd8);
    check(log_at(b, 3) == 32'h200, "R5", "target after slots", log_at(b, 3), 32'h200);
    check(log_at(b, 4) == 32'h204, "R5", "target stream", log_at(b, 4), 32'h204);
    check(find_pc(BPC + 32'd12) == -1, "R4", "no word past window", 32'(find_pc(BPC + 32'd12)), 32'hFFFF_FFFF);
  endtask

  task automatic t_taken_zero();
    int b;
    load_mem();
    mem[BPC >> 2] = br_word(0, 0);
    do_reset();
    resolve_after(1, 1'b1, 32'h300);
    repeat (5) @(negedge clk);
    #1;
    b = find_pc(BPC);
    check(log_at(b, 1) == 32'h300, "R9", "target right after branch", log_at(b, 1), 32'h300);
    check(b >= 0 && lcyc[b+1] - lcyc[b] == 3, "R9", "cycles branch to target",
          (b >= 0) ? 32'(lcyc[b+1] - lcyc[b]) : 32'hDEAD_DEAD, 32'd3);
  endtask

  task automatic t_not_taken();
    int b;
    load_mem();
    mem[BPC >> 2] = br_word(1, 0);
    do_reset();
    resolve_after(2, 1'b0, 32'h300);
    repeat (5) @(negedge clk);
    #1;
    b = find_pc(BPC);
    check(log_at(b, 1) == BPC + 32'd4, "R6", "slot word", log_at(b, 1), BPC + 32'd4);
    check(log_at(b, 2) == BPC + 32'd8, "R6", "resume sequential", log_at(b, 2), BPC + 32'd8);
    check(log_at(b, 3) == BPC + 32'd12, "R6", "nothing skipped", log_at(b, 3), BPC + 32'd12);
    check(b >= 0 && lcyc[b+2] - lcyc[b+1] == 2, "R4", "held until outcome",
          (b >= 0) ? 32'(lcyc[b+2] - lcyc[b+1]) : 32'hDEAD_DEAD, 32'd2);
  endtask

  task automatic t_bubble_in_window();
    int b;
    load_mem();
    mem[BPC >> 2] = br_word(2, 0);
    mem[(BPC >> 2) + 1] = mem[(BPC >> 2) + 1] | 32'h8000_0000;
    do_reset();
    resolve_after(1, 1'b1, 32'h280);
    repeat (6) @(negedge clk);
    #1;
    b = find_pc(BPC);
    check(log_at(b, 1) == BPC + 32'd4, "R7", "flagged slot", log_at(b, 1), BPC + 32'd4);
    check(log_at(b, 2) == BPC + 32'd8, "R7", "bubble not a slot", log_at(b, 2), BPC + 32'd8);
    check(log_at(b, 3) == 32'h280, "R7", "target after two slots", log_at(b, 3), 32'h280);
  endtask

  task automatic t_stall();
    int b;
    logic [31:0] s_instr, s_pc, s_addr;
    logic s_valid;
    bit same;
    load_mem();
    mem[BPC >> 2] = br_word(1, 0);
    do_reset();
    wait_branch();
    stall = 1'b1;
    @(negedge clk);
    #1;
    s_instr = issue_instr; s_pc = issue_pc; s_valid = issue_valid; s_addr = imem_addr;
    check(s_pc == BPC && s_valid, "R8", "branch frozen on issue", s_pc, BPC);
    same = 1'b1;
    repeat (2) begin
      @(negedge clk);
      #1;
      if (issue_instr != s_instr || issue_pc != s_pc || issue_valid != s_valid) same = 1'b0;
      check(imem_addr == s_addr, "R8", "address held", imem_addr, s_addr);
    end
    check(same, "R8", "issue outputs held", issue_pc, s_pc);
    stall = 1'b0;
    @(negedge clk);
    br_resolve = 1'b1;
    br_taken = 1'b1;
    br_target = 32'h240;
    @(negedge clk);
    br_resolve = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    b = find_pc(BPC);
    check(log_at(b, 1) == BPC + 32'd4, "R8", "slot kept over stall", log_at(b, 1), BPC + 32'd4);
    check(log_at(b, 2) == 32'h240, "R8", "target after stall", log_at(b, 2), 32'h240);
  endtask

  initial begin
    t_reset_and_stream();
    t_nflag();
    t_taken_slots();
    t_taken_zero();
    t_not_taken();
    t_bubble_in_window();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule